// File: doc/BRIEF.md
# Hypercube Node Router

This block is the switching core of one node in a binary hypercube network of 2^DIM_W nodes. Each node carries a DIM_W-bit identifier and one bidirectional link per dimension; the neighbour reached over link d has the same identifier with bit d inverted. The router has DIM_W+1 ports on each side: ports 0 to DIM_W-1 are the dimension links and port DIM_W is the local port, which injects traffic from the attached processor on the input side and ejects it on the output side.

Every flit carries its destination identifier beside the payload. The router XORs the destination with `node_id_i`. A zero result sends the flit to the local output. Any other result names the dimensions still to be crossed, and the router sends the flit out on the lowest of them. A flit therefore crosses dimensions in ascending order and reaches its destination in at most DIM_W hops. Each output holds one flit in a register. When several inputs want the same output, a round-robin arbiter picks one. The other inputs see `in_ready_o` low and must keep their flit until it is accepted.

`node_id_i` is static after reset. DIM_W may range from 2 to 6.

Top module: `hcube_router`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `out_valid_o` bit is low.
- R2: A flit whose destination equals `node_id_i` leaves on output port DIM_W, with destination and payload unchanged.
- R3: A flit whose destination differs from `node_id_i` leaves on output port d, where d is the lowest bit position set in destination XOR `node_id_i`. Destination and payload are unchanged.
- R4: An input flit is accepted in a cycle where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is never high without `in_valid_i`. The accepted flit appears on its output one cycle later.
- R5: While an output shows valid and its `out_ready_i` is low, that output keeps valid high and keeps its destination and payload stable.
- R6: In any cycle, at most one input is accepted for each output.
- R7: Each output has its own arbiter. After reset, its search starts at input 0. After a grant to input i, the next search starts at input i+1, wrapping past the last input to input 0. The first requesting input found in ascending order wins.
- R8: An output that holds a flit while its `out_ready_i` is low accepts no new flit. An output that is empty, or whose flit leaves in the same cycle, may accept a new flit.
- R9: Inputs that target different outputs are granted in the same cycle, without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | DIM_W | Identifier of this node, static |
| in_valid_i | input | DIM_W+1 | Per-input flit valid |
| in_dest_i | input | (DIM_W+1) x DIM_W | Per-input destination identifier |
| in_data_i | input | (DIM_W+1) x DATA_W | Per-input payload |
| in_ready_o | output | DIM_W+1 | Per-input accept |
| out_valid_o | output | DIM_W+1 | Per-output flit valid |
| out_dest_o | output | (DIM_W+1) x DIM_W | Per-output destination identifier |
| out_data_o | output | (DIM_W+1) x DATA_W | Per-output payload |
| out_ready_i | input | DIM_W+1 | Per-output downstream accept |

## Verification
The hardest case to reach from the ports is full contention: every input requests one output while that output is blocked, so the arbiter pointer must be seen to rotate once the output drains. The directed phases aim all inputs at a single chosen dimension, or at the local port, by XORing `node_id_i` with a fixed mask. These phases hold `out_ready_i` low until the register fills, then release it and check the grant order cycle by cycle. Random phases then mix destinations and downstream stalls under several node identifiers. Each phase is compared against a cycle-exact model held in the bench.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned MIN_DIM = 2;
  localparam int unsigned MAX_DIM = 6;

  // Next index on a ring of n entries.
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/hc_route_calc.sv
module hc_route_calc #(
  parameter int DIM_W = 4
) (
  input  logic [DIM_W-1:0] node_id_i,
  input  logic [DIM_W-1:0] dest_i,
  output logic [DIM_W:0]   tgt_o
);
  logic [DIM_W-1:0] diff;
  logic [DIM_W-1:0] low_bit;

  always_comb begin
    diff    = dest_i ^ node_id_i;
    // Isolate the lowest differing dimension.
    low_bit = diff & (~diff + 1'b1);
    tgt_o   = {(diff == '0), low_bit};
  end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb
  import hc_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic          found;
  int            win;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    win   = 0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && en_i && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
        win        = idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (found) ptr_q <= IW'(wrap_inc(win, N));
  end
endmodule

// File: rtl/hc_out_slot.sv
module hc_out_slot #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      dout_o  <= din_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hcube_router.sv
module hcube_router #(
  parameter int DIM_W  = 4,
  parameter int DATA_W = 16,
  localparam int NPORT = DIM_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DIM_W-1:0]              node_id_i,
  input  logic [NPORT-1:0]              in_valid_i,
  input  logic [NPORT-1:0][DIM_W-1:0]   in_dest_i,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data_i,
  output logic [NPORT-1:0]              in_ready_o,
  output logic [NPORT-1:0]              out_valid_o,
  output logic [NPORT-1:0][DIM_W-1:0]   out_dest_o,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data_o,
  input  logic [NPORT-1:0]              out_ready_i
);
  localparam int FW = DIM_W + DATA_W;

  logic [NPORT-1:0][NPORT-1:0] tgt;   // [in][out]
  logic [NPORT-1:0][NPORT-1:0] req;   // [out][in]
  logic [NPORT-1:0][NPORT-1:0] gnt;   // [out][in]
  logic [NPORT-1:0]            space;
  logic [NPORT-1:0][FW-1:0]    sel_flit;
  logic [NPORT-1:0][FW-1:0]    slot_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    hc_route_calc #(.DIM_W(DIM_W)) i_route (
      .node_id_i (node_id_i),
      .dest_i    (in_dest_i[i]),
      .tgt_o     (tgt[i])
    );
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = in_valid_i[i] & tgt[i][o];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    assign space[o] = ~out_valid_o[o] | out_ready_i[o];

    hc_rr_arb #(.N(NPORT)) i_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (space[o]),
      .req_i  (req[o]),
      .gnt_o  (gnt[o])
    );

    always_comb begin
      sel_flit[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt[o][i]) sel_flit[o] = sel_flit[o] | {in_dest_i[i], in_data_i[i]};
    end

    hc_out_slot #(.W(FW)) i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (|gnt[o]),
      .din_i   (sel_flit[o]),
      .ready_i (out_ready_i[o]),
      .valid_o (out_valid_o[o]),
      .dout_o  (slot_q[o])
    );

    assign out_dest_o[o] = slot_q[o][FW-1:DATA_W];
    assign out_data_o[o] = slot_q[o][DATA_W-1:0];
  end

  always_comb begin
    in_ready_o = '0;
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        in_ready_o[i] = in_ready_o[i] | gnt[o][i];
  end
endmodule

// File: rtl/hcube_router_chk.sv
module hcube_router_chk #(
  parameter int DIM_W  = 4,
  parameter int DATA_W = 16,
  localparam int NPORT = DIM_W + 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [DIM_W-1:0]              node_id_i,
  input logic [NPORT-1:0]              in_valid_i,
  input logic [NPORT-1:0][DIM_W-1:0]   in_dest_i,
  input logic [NPORT-1:0][DATA_W-1:0]  in_data_i,
  input logic [NPORT-1:0]              in_ready_o,
  input logic [NPORT-1:0]              out_valid_o,
  input logic [NPORT-1:0][DIM_W-1:0]   out_dest_o,
  input logic [NPORT-1:0][DATA_W-1:0]  out_data_o,
  input logic [NPORT-1:0]              out_ready_i
);
  function automatic int port_of(input logic [DIM_W-1:0] m);
    int p;
    p = DIM_W;
    for (int b = DIM_W - 1; b >= 0; b--) if (m[b]) p = b;
    return p;
  endfunction

  logic [NPORT-1:0]            acc;
  int                          pidx [NPORT];
  logic [NPORT-1:0][NPORT-1:0] aim;  // [out][in]

  always_comb begin
    acc = in_valid_i & in_ready_o;
    for (int i = 0; i < NPORT; i++) pidx[i] = port_of(in_dest_i[i] ^ node_id_i);
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++) aim[o][i] = acc[i] && (pidx[i] == o);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_ci
    assert_ready_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[i] |-> in_valid_i[i]);

    assert_local_delivery_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc[i] && in_dest_i[i] == node_id_i) |=>
        (out_valid_o[DIM_W] && out_dest_o[DIM_W] == $past(in_dest_i[i])
         && out_data_o[DIM_W] == $past(in_data_i[i])));

    assert_lowest_dim_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc[i] && in_dest_i[i] != node_id_i) |=>
        (out_valid_o[$past(pidx[i])] && out_data_o[$past(pidx[i])] == $past(in_data_i[i])));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_co
    assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |=>
        (out_valid_o[o] && $stable(out_dest_o[o]) && $stable(out_data_o[o])));

    assert_single_grant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(aim[o]) <= 1);

    assert_blocked_output_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[o] && !out_ready_i[o]) |-> (aim[o] == '0));
  end
endmodule

bind hcube_router hcube_router_chk #(.DIM_W(DIM_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_hcube_router.sv
`timescale 1ns/1ps
module test_hcube_router;
  localparam int D = 4;
  localparam int W = 16;
  localparam int N = D + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [D-1:0]         node_id = '0;
  logic [N-1:0]         in_valid = '0;
  logic [N-1:0][D-1:0]  in_dest = '0;
  logic [N-1:0][W-1:0]  in_data = '0;
  logic [N-1:0]         in_ready;
  logic [N-1:0]         out_valid;
  logic [N-1:0][D-1:0]  out_dest;
  logic [N-1:0][W-1:0]  out_data;
  logic [N-1:0]         out_ready = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  hcube_router #(.DIM_W(D), .DATA_W(W)) i_hcube_router (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(node_id),
    .in_valid_i(in_valid), .in_dest_i(in_dest), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_dest_o(out_dest), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  // Bench model state
  bit               m_ov  [N];
  logic [D-1:0]     m_od  [N];
  logic [W-1:0]     m_odt [N];
  int               m_ptr [N];
  bit               m_held[N];
  logic [N-1:0]     acc_prev;
  logic [D-1:0]     tmask;
  int               ready_pct;
  int               valid_pct;

  function automatic int exp_port(input logic [D-1:0] dst, input logic [D-1:0] id);
    logic [D-1:0] x;
    x = dst ^ id;
    for (int b = 0; b < D; b++) if (x[b]) return b;
    return D;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [D-1:0] id);
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; out_ready = '0;
    repeat (2) @(negedge clk);
    check("R1 out_valid in reset", 64'(out_valid), 64'd0);
    node_id = id;
    rst_n = 1'b1;
    for (int o = 0; o < N; o++) begin m_ov[o] = 0; m_ptr[o] = 0; m_held[o] = 0; end
    acc_prev = '0;
    #1 check("R1 out_valid after reset", 64'(out_valid), 64'd0);
  endtask

  // mode 0: random destinations, 1: all aimed at node_id^tmask
  task automatic step(input int mode);
    int   tgt [N];
    int   gnt [N];
    bit   erdy[N];
    int   nreq;
    int   ngr;
    int   cnt [N];
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (!(in_valid[i] && !acc_prev[i])) begin
        in_valid[i] = ($urandom % 100) < valid_pct;
        in_dest[i]  = (mode == 0) ? D'($urandom) : (node_id ^ tmask);
        in_data[i]  = W'($urandom);
      end
    end
    for (int o = 0; o < N; o++) out_ready[o] = ($urandom % 100) < ready_pct;
    #1;
    // outputs against model
    for (int o = 0; o < N; o++) begin
      string t;
      t = m_held[o] ? "R5 hold" : ((o == D) ? "R2 local" : "R3 dim");
      check({t, " valid"}, 64'(out_valid[o]), 64'(m_ov[o]));
      if (m_ov[o]) begin
        check({t, " dest"}, 64'(out_dest[o]), 64'(m_od[o]));
        check({t, " data"}, 64'(out_data[o]), 64'(m_odt[o]));
        if (o < D) check("R3 dest bit", 64'(out_dest[o][o] != node_id[o]), 64'd1);
      end
    end
    // expected grants
    for (int i = 0; i < N; i++) begin tgt[i] = exp_port(in_dest[i], node_id); erdy[i] = 0; end
    ngr = 0;
    for (int o = 0; o < N; o++) begin
      gnt[o] = -1;
      if (!m_ov[o] || out_ready[o])
        for (int k = 0; k < N; k++) begin
          int idx;
          idx = (m_ptr[o] + k) % N;
          if (gnt[o] < 0 && in_valid[idx] && tgt[idx] == o) gnt[o] = idx;
        end
      if (gnt[o] >= 0) begin erdy[gnt[o]] = 1; ngr++; end
    end
    for (int i = 0; i < N; i++) begin
      string t;
      nreq = 0;
      for (int j = 0; j < N; j++) if (in_valid[j] && tgt[j] == tgt[i]) nreq++;
      if (!in_valid[i])                           t = "R4 ready without valid";
      else if (m_ov[tgt[i]] && !out_ready[tgt[i]]) t = "R8 blocked";
      else if (nreq > 1)                          t = "R7 round robin";
      else                                        t = "R4 accept";
      check(t, 64'(in_ready[i]), 64'(erdy[i]));
    end
    for (int o = 0; o < N; o++) cnt[o] = 0;
    for (int i = 0; i < N; i++) if (in_ready[i]) cnt[tgt[i]]++;
    for (int o = 0; o < N; o++) check("R6 one grant per output", 64'(cnt[o] <= 1), 64'd1);
    check("R9 parallel grants", 64'($countones(in_ready)), 64'(ngr));
    acc_prev = in_ready & in_valid;
    // advance model to post-edge state
    for (int o = 0; o < N; o++) begin
      m_held[o] = m_ov[o] && !out_ready[o];
      if (gnt[o] >= 0) begin
        m_ov[o] = 1; m_od[o] = in_dest[gnt[o]]; m_odt[o] = in_data[gnt[o]];
        m_ptr[o] = (gnt[o] + 1) % N;
      end else if (out_ready[o]) m_ov[o] = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(D'(ph * 5 + 3));
      // directed: every input targets one dimension (or local), output blocked then drained
      tmask = (ph == 3) ? '0 : D'(1 << (ph % D));
      valid_pct = 100;
      ready_pct = 0;
      repeat (6) step(1);
      ready_pct = 100;
      repeat (12) step(1);
      ready_pct = 50;
      repeat (12) step(1);
      // random mix
      valid_pct = 70;
      ready_pct = 60;
      repeat (500) step(0);
      valid_pct = 100;
      ready_pct = 20;
      repeat (100) step(0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule